// File: doc/BRIEF.md
# Page Buffer Write Controller

This block is the write path of a byte-wide nonvolatile memory that programs one whole page in a single timed operation. Bytes arrive on a valid/ready load stream, each with an 18-bit address and 8 bits of data. The low 7 address bits pick the column inside a 128-byte page. The upper 11 bits pick the page. Accepted bytes collect in a page buffer that holds data and a loaded flag per column. Each accepted byte restarts an inactivity timer. When that timer runs out, the block starts a timed internal write. During that write it streams all 128 columns of the target page to an array model that lives outside the block, and erase and program happen together in that one pass.

The load stream follows valid/ready rules. A byte transfers on a rising clock edge where `load_valid`, `load_ready` and `wr_enable` are all high. `load_ready` is low for as long as an internal write or a chip erase is running. A source may hold `load_valid` high against a low `load_ready`, and nothing is taken until ready returns. With `wr_enable` low, a byte offered while ready is high is dropped, not stalled. The array port has no back-pressure. The array must take one byte per cycle while `arr_we` is high, and must clear itself to FFh on the single-cycle `arr_erase` pulse.

Top module: `page_write_ctrl`

## Requirements
- R1: A commit writes exactly 128 bytes to the array, one per cycle. The columns go in ascending order from 0 to 127. Address bits 17..7 stay fixed at the target page, and bits 6..0 carry the column.
- R2: A byte is accepted only when `load_valid`, `load_ready` and `wr_enable` are all high. With `wr_enable` low, an offered byte opens no load phase and causes no commit.
- R3: A second byte loaded to a column that already holds data replaces the buffered value. The commit carries the later value.
- R4: Every accepted byte restarts the idle count. `busy` rises exactly CLOSE_CYC clock cycles after the edge that accepted the last byte. Bytes spaced closer than that keep the phase open for any number of loads.
- R5: The page committed is given by bits 17..7 of the last byte accepted. Columns loaded under an earlier page value are carried over to the final page. No other page is written.
- R6: Every column not loaded in the current phase is written as FFh.
- R7: An internal write holds `busy` high for exactly PROG_CYC cycles, and `load_ready` stays low throughout. Bytes offered in that time are not taken and start no later commit.
- R8: The loaded flags clear when a new load phase opens. A column loaded only in an earlier phase is committed as FFh.
- R9: `erase_req` with `wr_enable` high, while the block is idle (no load phase and not busy), holds `busy` for exactly ERASE_CYC cycles. It then gives one `arr_erase` pulse in the last busy cycle. An `erase_req` during a load phase is ignored.
- R10: After reset, `busy`, `arr_we` and `arr_erase` are low and `load_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Load byte offered |
| load_ready | output | 1 | Block can take a load byte |
| load_addr | input | 18 | Byte address: page in 17..7, column in 6..0 |
| load_data | input | 8 | Byte value |
| wr_enable | input | 1 | External permission for loads and erase |
| erase_req | input | 1 | Request to clear the whole array |
| busy | output | 1 | Internal write or erase in progress |
| arr_we | output | 1 | Array write strobe, one byte per cycle |
| arr_addr | output | 18 | Array write address |
| arr_data | output | 8 | Array write data |
| arr_erase | output | 1 | One-cycle whole-array clear |

## Verification
The bench loads a phase that overwrites one column and moves to a second page on its last byte. A design that took the first byte's page, or kept the first value, would write the wrong page or the old data. The bench measures the cycle at which `busy` rises and how long it stays high. A timer that was off by one, or that was not re-armed by each load, would start the commit early or late, or would close a phase that closely spaced loads should keep open. The bench also offers bytes while busy, with `wr_enable` low, and from a previous phase. A design that let any of these through would commit an extra page or leave stale columns where FFh belongs. Finally, it sends an erase request during a load phase, which a careless design would act on.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_PROG  = 2'd2,
    ST_ERASE = 2'd3
  } pwc_state_e;
endpackage

// File: rtl/pwc_span_cnt.sv
module pwc_span_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_o <= '0;
    else if (clr) cnt_o <= '0;
    else if (en)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int COL_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              fresh_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int COLS = 1 << COL_W;

  logic [DATA_W-1:0] cell_q [COLS];
  logic [COLS-1:0]   loaded_q;

  always_ff @(posedge clk) begin
    if (wr_i) cell_q[col_i] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
    end else if (wr_i) begin
      if (fresh_i) loaded_q <= COLS'(1) << col_i;
      else         loaded_q[col_i] <= 1'b1;
    end
  end

  assign rd_data_o = loaded_q[rd_col_i] ? cell_q[rd_col_i] : {DATA_W{1'b1}};
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W    = 18,
  parameter int COL_W     = 7,
  parameter int DATA_W    = 8,
  parameter int CLOSE_CYC = 50,
  parameter int PROG_CYC  = 300,
  parameter int ERASE_CYC = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              wr_enable,
  input  logic              erase_req,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              arr_erase
);
  import pwc_pkg::*;

  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int COLS     = 1 << COL_W;
  localparam int OP_MAX   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int OPW      = $clog2(OP_MAX + 1);
  localparam int IDW      = $clog2(CLOSE_CYC + 1);
  localparam logic [OPW-1:0] PROG_LAST  = OPW'(PROG_CYC - 1);
  localparam logic [OPW-1:0] ERASE_LAST = OPW'(ERASE_CYC - 1);
  localparam logic [OPW-1:0] COLS_OP    = OPW'(COLS);
  localparam logic [IDW-1:0] CLOSE_LAST = IDW'(CLOSE_CYC - 1);

  pwc_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [IDW-1:0]   idle_cnt;
  logic [OPW-1:0]   op_cnt;
  logic             accept, in_op;

  assign in_op      = (state_q == ST_PROG) || (state_q == ST_ERASE);
  assign load_ready = !in_op;
  assign busy       = in_op;
  assign accept     = load_valid && load_ready && wr_enable;

  pwc_span_cnt #(.W(IDW)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept || (state_q != ST_LOAD)),
    .en    (state_q == ST_LOAD),
    .cnt_o (idle_cnt)
  );

  pwc_span_cnt #(.W(OPW)) u_op (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_op),
    .en    (in_op),
    .cnt_o (op_cnt)
  );

  pwc_page_buf #(.COL_W(COL_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (accept),
    .fresh_i   (state_q == ST_IDLE),
    .col_i     (load_addr[COL_W-1:0]),
    .data_i    (load_data),
    .rd_col_i  (op_cnt[COL_W-1:0]),
    .rd_data_o (arr_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept)                      state_d = ST_LOAD;
        else if (erase_req && wr_enable) state_d = ST_ERASE;
      end
      ST_LOAD: begin
        if (!accept && (idle_cnt == CLOSE_LAST)) state_d = ST_PROG;
      end
      ST_PROG: begin
        if (op_cnt == PROG_LAST) state_d = ST_IDLE;
      end
      ST_ERASE: begin
        if (op_cnt == ERASE_LAST) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) row_q <= load_addr[ADDR_W-1:COL_W];
    end
  end

  assign arr_we    = (state_q == ST_PROG) && (op_cnt < COLS_OP);
  assign arr_addr  = {row_q, op_cnt[COL_W-1:0]};
  assign arr_erase = (state_q == ST_ERASE) && (op_cnt == ERASE_LAST);
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int ADDR_W = 18,
  parameter int COL_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              load_ready,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              arr_erase
);
  a_r1_first_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !$past(arr_we)) |-> (arr_addr[COL_W-1:0] == '0));

  a_r1_col_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[COL_W-1:0] == $past(arr_addr[COL_W-1:0]) + 1'b1));

  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:COL_W] == $past(arr_addr[ADDR_W-1:COL_W])));

  a_r7_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  a_r7_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_ready);

  a_r9_erase_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> (busy && !arr_we));

  a_r9_erase_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |=> !arr_erase);
endmodule

bind page_write_ctrl pwc_checker #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_pwc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .load_ready (load_ready),
  .arr_we     (arr_we),
  .arr_addr   (arr_addr),
  .arr_erase  (arr_erase)
);

// File: tb/page_write_ctrl_bench.sv
module page_write_ctrl_bench;
  localparam int CLOSE = 50;
  localparam int PROG  = 300;
  localparam int ERASE = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [17:0] load_addr = '0;
  logic [7:0]  load_data = '0;
  logic        wr_enable = 1'b1;
  logic        erase_req = 1'b0;
  logic        busy, arr_we, arr_erase;
  logic [17:0] arr_addr;
  logic [7:0]  arr_data;

  always #5 clk = ~clk;

  page_write_ctrl #(.CLOSE_CYC(CLOSE), .PROG_CYC(PROG), .ERASE_CYC(ERASE)) u_page_write_ctrl (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_addr(load_addr), .load_data(load_data), .wr_enable(wr_enable),
    .erase_req(erase_req), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_data(arr_data), .arr_erase(arr_erase)
  );

  logic [7:0]  mem [logic [17:0]];
  int          n_cmp = 0, n_bad = 0;
  int          wr_count = 0, off_page = 0, erase_count = 0;
  logic [10:0] exp_row = '0;

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] = arr_data;
      wr_count++;
      if (arr_addr[17:7] != exp_row) off_page++;
    end
    if (arr_erase) begin
      mem.delete();
      erase_count++;
    end
  end

  function automatic logic [7:0] rd(input logic [17:0] a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_byte(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    load_valid = 1'b1; load_addr = a; load_data = d;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // {address, data} loads of the first phase; the last one moves to page 2
  localparam logic [25:0] LOADS [5] = '{
    {18'h00085, 8'h11}, {18'h00080, 8'h22}, {18'h000FF, 8'h33},
    {18'h00085, 8'h44}, {18'h00109, 8'h55}
  };
  // {address, expected array byte} after the first commit
  localparam logic [25:0] EXPECT [6] = '{
    {18'h00105, 8'h44}, {18'h00100, 8'h22}, {18'h0017F, 8'h33},
    {18'h00109, 8'h55}, {18'h00101, 8'hFF}, {18'h0017E, 8'hFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int blen;
    repeat (3) @(negedge clk);
    check("R10 busy after reset", busy, 0);
    check("R10 ready after reset", load_ready, 1);
    check("R10 arr_we after reset", arr_we, 0);
    check("R10 arr_erase after reset", arr_erase, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Phase 1: overwrite (R3), page from last byte (R5), FFh fill (R6)
    exp_row = 11'd2;
    for (int i = 0; i < 5; i++) begin
      load_byte(LOADS[i][25:8], LOADS[i][7:0]);
      if (i == 2) begin
        erase_req = 1'b1;          // R9: ignored inside a load phase
        @(negedge clk);
        erase_req = 1'b0;
      end
    end
    repeat (CLOSE - 1) @(negedge clk);
    check("R4 busy one cycle before close", busy, 0);
    @(negedge clk);
    check("R4 busy at close", busy, 1);
    // R7: offer a byte through the whole busy time
    load_valid = 1'b1; load_addr = 18'h00101; load_data = 8'hAA;
    blen = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
      blen++;
      if (load_ready) check("R7 ready low while busy", 1, 0);
    end
    load_valid = 1'b0;
    check("R7 busy length", blen, PROG);
    check("R1 bytes committed", wr_count, 128);
    check("R5 off-page writes", off_page, 0);
    check("R5 first page untouched", mem.exists(18'h00085), 0);
    check("R9 erase during load ignored", erase_count, 0);
    for (int i = 0; i < 6; i++)
      check("R3/R5/R6 array byte", rd(EXPECT[i][25:8]), EXPECT[i][7:0]);
    repeat (CLOSE + 5) @(negedge clk);
    check("R7 byte offered while busy not taken", busy, 0);
    check("R7 no extra commit", wr_count, 128);

    // Phase 2: flags cleared (R8)
    load_byte(18'h00103, 8'h77);
    wait_idle();
    repeat (CLOSE + 5) @(negedge clk);
    wait_idle();
    check("R8 new byte", rd(18'h00103), 8'h77);
    check("R8 stale column filled", rd(18'h00105), 8'hFF);
    check("R8 stale column 0 filled", rd(18'h00100), 8'hFF);

    // Window kept open by closely spaced loads (R4)
    exp_row = 11'd4;
    for (int i = 0; i < 6; i++) begin
      load_byte(18'h00200 + 18'(i), 8'h30 + 8'(i));
      repeat (CLOSE - 3) @(negedge clk);
      check("R4 window stays open", busy, 0);
    end
    repeat (10) @(negedge clk);
    wait_idle();
    check("R4 all spaced bytes kept", rd(18'h00205), 8'h35);
    check("R4 first spaced byte kept", rd(18'h00200), 8'h30);
    check("R5 off-page writes", off_page, 0);

    // Enable low (R2)
    wr_count = 0;
    wr_enable = 1'b0;
    load_byte(18'h00300, 8'h99);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    check("R2 erase blocked", busy, 0);
    repeat (CLOSE + 10) @(negedge clk);
    check("R2 no commit when disabled", wr_count, 0);
    check("R2 busy stays low", busy, 0);
    wr_enable = 1'b1;

    // Chip erase (R9)
    @(negedge clk);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    blen = 0;
    for (int i = 0; i < 2000 && busy; i++) begin
      blen++;
      @(negedge clk);
    end
    check("R9 erase busy length", blen, ERASE);
    check("R9 one erase pulse", erase_count, 1);
    check("R9 array cleared", rd(18'h00103), 8'hFF);
    check("R9 array empty", mem.num(), 0);

    finish_run();
  end
endmodule